// File: doc/BRIEF.md
# Slave Address Matcher for a Two-Wire Serial Bus

This block decides whether the first byte of a bus transfer addresses this device. A byte-level receiver in front of it signals START and STOP events and hands over each completed byte with a valid strobe. After a START or repeated START, the matcher compares only the first byte against a stored seven-bit own address and a stored direction compare bit. It then reports the outcome as a one-cycle match pulse and as a sticky "addressed" flag.

A mode input chooses between the two address formats. In short-address mode, only the seven address bits of the byte count and its direction bit is ignored. In long-address mode, the whole byte is compared, including the direction bit, which is checked against the stored compare bit. In long-address mode, software reads the second address byte from the receiver and checks it itself. If that byte matches, software sets the stored compare bit to 1, so that a repeated START carrying a read direction is then matched by this block without help.

Top module: `slv_addr_match`

## Requirements
- R1: `tenBitMode` = 0 selects short-address matching and `tenBitMode` = 1 selects long-address matching. In a received byte, bits [7:1] carry the address and bit [0] carries the direction (1 = read).
- R2: In short-address mode, a byte matches when `addrByte[7:1]` equals `ownAddr`. Both `addrByte[0]` and `ownRw` have no effect on the result.
- R3: In long-address mode, a byte matches only when `addrByte[7:1]` equals `ownAddr` and `addrByte[0]` equals `ownRw`.
- R4: `matchPulse` is high for exactly one cycle: the cycle after a compared byte's `byteValid` cycle, and only when that byte matches.
- R5: A matching compared byte sets `addrFlag` to 1 in the cycle after its `byteValid`. The flag then holds until a STOP or a non-matching compared byte.
- R6: Only the first `byteValid` after a `startSeen` is compared. A `byteValid` at any other time (later data bytes, or any byte before the first START) produces no pulse and leaves `addrFlag` unchanged.
- R7: `stopSeen` clears `addrFlag` in the next cycle and ends the wait for an address byte. A `byteValid` in the same cycle as `stopSeen` is not compared.
- R8: A compared first byte that does not match clears `addrFlag` in the next cycle, even if the flag was set by an earlier transfer.
- R9: After software sets `ownRw` to 1 in long-address mode, a repeated START followed by the byte {`ownAddr`, 1} produces a match.
- R10: During and right after reset, `matchPulse` and `addrFlag` are 0 and no byte is compared until a `startSeen` arrives.
- R11: A `byteValid` in the same cycle as `startSeen` is not compared. The `startSeen` arms the block for the following byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startSeen | input | 1 | One-cycle strobe marking a START or repeated START |
| stopSeen | input | 1 | One-cycle strobe marking a STOP |
| byteValid | input | 1 | One-cycle strobe: `addrByte` holds a completed byte |
| addrByte | input | 8 | Received byte; [7:1] address, [0] direction |
| ownAddr | input | 7 | Stored own slave address |
| ownRw | input | 1 | Stored direction compare bit (used in long-address mode) |
| tenBitMode | input | 1 | 0 = short-address mode, 1 = long-address mode |
| matchPulse | output | 1 | One-cycle pulse on an address match |
| addrFlag | output | 1 | Sticky addressed-as-slave flag |

## Verification
The embedded assertions check, on every cycle, four properties: the match pulse never lasts two cycles; a pulse always comes with a set flag; the flag is cleared after a STOP; and the flag does not move unless a compare or a STOP took place. They also check that every pulse was earned by the byte presented one cycle earlier, under the rule of the mode in force at that time. Other behaviours can only be shown by the bench's scenarios, which a behavioural model compares on every clock:
- a byte that should match is not missed;
- data bytes after the address are ignored;
- simultaneous START/STOP/byte events resolve in the stated order;
- a long-address repeated START with read direction is matched once software has set the compare bit.

// File: rtl/sam_pkg.sv
package sam_pkg;

  // Address format selected by the mode input
  typedef enum logic {
    MODE_SHORT = 1'b0,
    MODE_LONG  = 1'b1
  } addrMode_t;

  // Control sequencing state
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } ctrlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic doCompare;  // evaluate the presented byte now
    logic doClear;    // drop the addressed flag
  } samStrobe_t;

endpackage

// File: rtl/sam_ctrl.sv
module sam_ctrl
  import sam_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic       byteValid,
  output samStrobe_t strobe
);

  ctrlState_t state, stateNext;
  logic       compareNow;

  // A byte is compared only while armed, and never in a cycle that also
  // carries a bus event (START re-arms, STOP aborts).
  assign compareNow = (state == ST_ARMED) && byteValid && !startSeen && !stopSeen;

  always_comb begin
    stateNext = state;
    if (startSeen)
      stateNext = ST_ARMED;
    else if (stopSeen || compareNow)
      stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      state <= ST_IDLE;
    else
      state <= stateNext;
  end

  always_comb begin
    strobe           = '0;
    strobe.doCompare = compareNow;
    strobe.doClear   = stopSeen;
  end

  AST_ARM_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> (state == ST_ARMED)); // R11

  AST_DISARM_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (stopSeen && !startSeen) |=> (state == ST_IDLE)); // R7

  AST_ONE_COMPARE_PER_START: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doCompare && !startSeen) |=> !strobe.doCompare); // R6

endmodule

// File: rtl/sam_datapath.sv
module sam_datapath
  import sam_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  samStrobe_t        strobe,
  input  logic [BYTE_W-1:0] addrByte,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              ownRw,
  input  logic              tenBitMode,
  output logic              matchPulse,
  output logic              addrFlag
);

  logic [ADDR_W-1:0] bitEq;
  logic              rwOk;
  logic              hit;

  // Per-bit equality of the address field, byte bit i+1 against stored bit i
  for (genvar i = 0; i < ADDR_W; i++) begin : g_addrBit
    assign bitEq[i] = ~(addrByte[i+1] ^ ownAddr[i]);
  end

  // Direction bit only takes part in long-address mode
  always_comb begin
    unique case (addrMode_t'(tenBitMode))
      MODE_SHORT: rwOk = 1'b1;
      MODE_LONG:  rwOk = (addrByte[0] == ownRw);
      default:    rwOk = 1'b0;
    endcase
  end

  assign hit = (&bitEq) && rwOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchPulse <= 1'b0;
      addrFlag   <= 1'b0;
    end else begin
      matchPulse <= strobe.doCompare && hit;
      if (strobe.doClear)
        addrFlag <= 1'b0;
      else if (strobe.doCompare)
        addrFlag <= hit;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> !matchPulse); // R4

  AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> addrFlag); // R5

  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doClear |=> !addrFlag); // R7

  AST_FLAG_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.doClear && !strobe.doCompare) |=> $stable(addrFlag)); // R6

endmodule

// File: rtl/slv_addr_match.sv
module slv_addr_match
  import sam_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] addrByte,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              ownRw,
  input  logic              tenBitMode,
  output logic              matchPulse,
  output logic              addrFlag
);

  samStrobe_t strobe;

  sam_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startSeen (startSeen),
    .stopSeen  (stopSeen),
    .byteValid (byteValid),
    .strobe    (strobe)
  );

  sam_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .addrByte   (addrByte),
    .ownAddr    (ownAddr),
    .ownRw      (ownRw),
    .tenBitMode (tenBitMode),
    .matchPulse (matchPulse),
    .addrFlag   (addrFlag)
  );

  AST_SHORT_ADDR_EARNED: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && !$past(tenBitMode)) |->
      ($past(addrByte[BYTE_W-1:1]) == $past(ownAddr))); // R2

  AST_LONG_ADDR_EARNED: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && $past(tenBitMode)) |->
      ($past(addrByte) == {$past(ownAddr), $past(ownRw)})); // R3

  AST_PULSE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(byteValid)); // R4

endmodule

// File: tb/slv_addr_match_test.sv
`timescale 1ns/1ps
module slv_addr_match_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startSeen = 1'b0;
  logic       stopSeen = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] addrByte = 8'h00;
  logic [6:0] ownAddr = 7'h00;
  logic       ownRw = 1'b0;
  logic       tenBitMode = 1'b0;
  logic       matchPulse;
  logic       addrFlag;

  int    vectors = 0;
  int    misses = 0;
  int    cycles = 0;
  string curReq = "R10";
  bit    done = 1'b0;

  // reference model state
  bit mArmed = 1'b0;
  bit mFlag = 1'b0;
  bit mPulse = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  slv_addr_match uut (
    .clk        (clk),
    .rstN       (rstN),
    .startSeen  (startSeen),
    .stopSeen   (stopSeen),
    .byteValid  (byteValid),
    .addrByte   (addrByte),
    .ownAddr    (ownAddr),
    .ownRw      (ownRw),
    .tenBitMode (tenBitMode),
    .matchPulse (matchPulse),
    .addrFlag   (addrFlag)
  );

  // Behavioural model: advances on each rising edge from the driven inputs
  always @(posedge clk) begin
    bit take;
    bit same;
    if (!rstN) begin
      mArmed = 1'b0;
      mFlag  = 1'b0;
      mPulse = 1'b0;
    end else begin
      take = mArmed && byteValid && !startSeen && !stopSeen;
      if (tenBitMode) same = (addrByte == {ownAddr, ownRw});
      else            same = (addrByte[7:1] == ownAddr);
      mPulse = take && same;
      if (stopSeen)  mFlag = 1'b0;
      else if (take) mFlag = same;
      if (startSeen)              mArmed = 1'b1;
      else if (stopSeen || take)  mArmed = 1'b0;
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (matchPulse !== mPulse) begin
        misses++;
        $display("FAIL %s matchPulse actual=%b expected=%b at cycle %0d",
                 curReq, matchPulse, mPulse, cycles);
      end
      if (addrFlag !== mFlag) begin
        misses++;
        $display("FAIL %s addrFlag actual=%b expected=%b at cycle %0d",
                 curReq, addrFlag, mFlag, cycles);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      misses++;
      $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  // Drive one cycle of events, then return to quiet
  task automatic step(input bit st, input bit sp, input bit bv, input logic [7:0] b);
    @(posedge clk); #1;
    startSeen = st;
    stopSeen  = sp;
    byteValid = bv;
    addrByte  = b;
    @(posedge clk); #1;
    startSeen = 1'b0;
    stopSeen  = 1'b0;
    byteValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  // Point check of a specific expected flag value (independent of model)
  task automatic expectFlag(input string req, input bit exp);
    @(negedge clk);
    vectors++;
    if (addrFlag !== exp) begin
      misses++;
      $display("FAIL %s point addrFlag actual=%b expected=%b", req, addrFlag, exp);
    end
  endtask

  initial begin
    // R10: reset
    curReq = "R10";
    idle(4);
    expectFlag("R10", 1'b0);
    @(posedge clk); #1 rstN = 1'b1;
    step(1'b0, 1'b0, 1'b1, 8'hB4);  // unarmed byte after reset, ignored
    idle(2);
    expectFlag("R10", 1'b0);

    // R2: short mode, direction bit ignored
    curReq = "R2";
    tenBitMode = 1'b0; ownAddr = 7'h5A; ownRw = 1'b0;
    step(1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b1, {7'h5A, 1'b1});
    idle(1);
    expectFlag("R2", 1'b1);

    // R6: data bytes after the address are not compared
    curReq = "R6";
    step(1'b0, 1'b0, 1'b1, {7'h11, 1'b0});
    step(1'b0, 1'b0, 1'b1, {7'h5A, 1'b0});
    idle(1);
    expectFlag("R6", 1'b1);

    // R7: stop clears
    curReq = "R7";
    step(1'b0, 1'b1, 1'b0, 8'h00);
    idle(1);
    expectFlag("R7", 1'b0);

    // R2: stored compare bit ignored in short mode
    curReq = "R2";
    ownRw = 1'b1;
    step(1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b1, {7'h5A, 1'b0});
    idle(1);
    expectFlag("R2", 1'b1);

    // R8: repeated start with a foreign address clears the flag
    curReq = "R8";
    step(1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b1, {7'h5B, 1'b0});
    idle(1);
    expectFlag("R8", 1'b0);

    // R3: long mode compares the direction bit too
    curReq = "R3";
    tenBitMode = 1'b1; ownAddr = 7'h79; ownRw = 1'b0;
    step(1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b1, {7'h79, 1'b0});
    idle(1);
    expectFlag("R3", 1'b1);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b1, {7'h79, 1'b1});
    idle(1);
    expectFlag("R3", 1'b0);

    // R9: software sets compare bit, repeated start with read matches
    curReq = "R9";
    step(1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b1, {7'h79, 1'b0});
    step(1'b0, 1'b0, 1'b1, 8'hC3);  // second address byte, left to software
    ownRw = 1'b1;
    step(1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b1, {7'h79, 1'b1});
    idle(1);
    expectFlag("R9", 1'b1);

    // R7: stop in the same cycle as a byte wins
    curReq = "R7";
    step(1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b1, 1'b1, {7'h79, 1'b1});
    idle(1);
    expectFlag("R7", 1'b0);

    // R11: start in the same cycle as a byte; byte not compared, next one is
    curReq = "R11";
    step(1'b1, 1'b0, 1'b1, {7'h79, 1'b1});
    idle(1);
    expectFlag("R11", 1'b0);
    step(1'b0, 1'b0, 1'b1, {7'h79, 1'b1});
    idle(1);
    expectFlag("R11", 1'b1);

    // R4: byte with no preceding start gives no pulse
    curReq = "R4";
    step(1'b0, 1'b0, 1'b1, {7'h79, 1'b1});
    idle(2);

    // R1: mixed sweep over both modes
    curReq = "R1";
    for (int k = 0; k < 400; k++) begin
      tenBitMode = $urandom_range(0, 1);
      ownRw      = $urandom_range(0, 1);
      ownAddr    = 7'h2C;
      step(($urandom_range(0, 3) != 0), ($urandom_range(0, 7) == 0), 1'b0, 8'h00);
      if ($urandom_range(0, 1) == 1)
        step(1'b0, 1'b0, 1'b1, {7'h2C, 1'($urandom_range(0, 1))});
      else
        step(1'b0, 1'b0, 1'b1, 8'($urandom_range(0, 255)));
    end
    idle(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule